// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer core of a small 8-bit processor in which every transfer crosses one shared internal bus. The bus connects the program counter, the stack pointer, the memory address and memory buffer registers, the instruction register, a parameterised bank of general-purpose registers, the operand latch Y and the result register Z. An external sequencer drives the per-register drive enables, the per-register load enables, a Z capture strobe and an ALU function code each cycle. The bench stands in for that sequencer.

The ALU always takes Y as its first operand and the live bus value as its second. Z captures the ALU output and can only drive the bus back out. So an operation costs at least a Y staging cycle, an execute cycle and a Z move-out cycle. The program counter and the stack pointer have no incrementers of their own: they step through the ALU and Z. Memory is reached only through MAR (the address) and MBR (the data). A read is requested once and completes when memory signals ready. A write lasts one cycle.

Top module: `single_bus_datapath`

## Requirements
- R1: After reset is applied, every register (PC, SP, MAR, MBR, IR, Y, Z and all general-purpose registers) drives 0x00 onto the bus when selected.
- R2: Drive enable bits select the bus source: bit 0 PC, 1 SP, 2 MAR, 3 MBR, 4 IR, 5 Y, 6 Z, 7+i general-purpose register i. With exactly one bit set, the bus carries that register's value in the same cycle. With none set, the bus reads 0x00.
- R3: When more than one drive enable is set, the error output is high in that cycle. Otherwise it is low.
- R4: Load enable bits select the bus destinations: bit 0 PC, 1 SP, 2 MAR, 3 MBR, 4 IR, 5 Y, 6+i general-purpose register i. Each selected register takes the bus value at the clock edge.
- R5: Z has no load enable. It changes only at an edge where the Z capture strobe is high. With the strobe low, an ALU code and a bus value leave Z unchanged.
- R6: The ALU result is formed modulo 256 from A = Y and B = bus. The function codes are: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 B, 6 B+1, 7 B-1.
- R7: A read request, when no read is pending, makes the read output high from the next cycle on. It stays high until a cycle in which ready is high, and falls after that edge. A request made while a read is already pending is ignored. The memory address output always equals MAR.
- R8: The write output follows the write request in the same cycle, with the write data output equal to MBR and the address equal to MAR.
- R9: At the edge that completes a read, MBR takes the memory read data, even if the MBR load enable is also set in that cycle. Ready with no read pending has no effect.
- R10: The instruction output always shows the current IR content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drive_en_i | input | 7+NUM_GPR | Per-register bus drive enables |
| load_en_i | input | 6+NUM_GPR | Per-register load enables |
| z_ld_i | input | 1 | Capture ALU result into Z |
| alu_op_i | input | 3 | ALU function code |
| mem_rd_req_i | input | 1 | Start a memory read at MAR |
| mem_wr_req_i | input | 1 | Write MBR to memory at MAR this cycle |
| mem_rdy_i | input | 1 | Read data valid |
| mem_rdata_i | input | W | Memory read data |
| mem_addr_o | output | W | Memory address (MAR) |
| mem_rd_o | output | 1 | Read pending |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | W | Write data (MBR) |
| bus_o | output | W | Internal bus value |
| bus_err_o | output | 1 | Several drivers enabled |
| ir_o | output | W | Instruction register |

## Verification
MBR has two writers that can meet in one edge: a read completing from memory, and a bus transfer with the MBR load enable set. The bench provokes the collision by holding a read pending and then raising ready in the same cycle that a general-purpose register is driven with the MBR load set. It then moves MBR onto the bus, and the memory word must be there, not the register value. A second overlap pairs a fresh read request with a read that is already pending. The bench judges it by the read output dropping after a single ready.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned DRV_PC   = 0;
  localparam int unsigned DRV_SP   = 1;
  localparam int unsigned DRV_MAR  = 2;
  localparam int unsigned DRV_MBR  = 3;
  localparam int unsigned DRV_IR   = 4;
  localparam int unsigned DRV_Y    = 5;
  localparam int unsigned DRV_Z    = 6;
  localparam int unsigned DRV_GPR0 = 7;

  localparam int unsigned LD_PC   = 0;
  localparam int unsigned LD_SP   = 1;
  localparam int unsigned LD_MAR  = 2;
  localparam int unsigned LD_MBR  = 3;
  localparam int unsigned LD_IR   = 4;
  localparam int unsigned LD_Y    = 5;
  localparam int unsigned LD_GPR0 = 6;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_PASS = 3'd5,
    ALU_INC  = 3'd6,
    ALU_DEC  = 3'd7
  } alu_op_e;
endpackage

// File: rtl/sbd_alu.sv
module sbd_alu
  import sbd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (alu_op_e'(op_i))
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = a_i - b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_PASS: res_o = b_i;
      ALU_INC:  res_o = b_i + ONE;
      ALU_DEC:  res_o = b_i - ONE;
      default:  res_o = b_i;
    endcase
  end
endmodule

// File: rtl/sbd_bus.sv
module sbd_bus #(
  parameter int unsigned W       = 8,
  parameter int unsigned NUM_SRC = 11
) (
  input  logic [NUM_SRC-1:0][W-1:0] src_i,
  input  logic [NUM_SRC-1:0]        drive_en_i,
  output logic [W-1:0]              bus_o,
  output logic                      err_o
);
  localparam int unsigned CW = $clog2(NUM_SRC + 1);

  logic [CW-1:0] n_drv;

  // wired-OR; value is meaningless when err_o is high
  always_comb begin
    bus_o = '0;
    n_drv = '0;
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      if (drive_en_i[i]) begin
        bus_o = bus_o | src_i[i];
        n_drv = n_drv + CW'(1);
      end
    end
  end

  assign err_o = (n_drv > CW'(1));
endmodule

// File: rtl/sbd_mem_port.sv
module sbd_mem_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic rdy_i,
  output logic rd_o,
  output logic mbr_fill_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (pend_q && rdy_i)   pend_q <= 1'b0;
    else if (!pend_q && rd_req_i) pend_q <= 1'b1;
  end

  assign rd_o       = pend_q;
  assign mbr_fill_o = pend_q & rdy_i;
endmodule

// File: rtl/single_bus_datapath.sv
module single_bus_datapath
  import sbd_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned NUM_GPR = 4,
  localparam int unsigned NUM_SRC = DRV_GPR0 + NUM_GPR,
  localparam int unsigned NUM_DST = LD_GPR0 + NUM_GPR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] drive_en_i,
  input  logic [NUM_DST-1:0] load_en_i,
  input  logic               z_ld_i,
  input  logic [2:0]         alu_op_i,
  input  logic               mem_rd_req_i,
  input  logic               mem_wr_req_i,
  input  logic               mem_rdy_i,
  input  logic [W-1:0]       mem_rdata_i,
  output logic [W-1:0]       mem_addr_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [W-1:0]       mem_wdata_o,
  output logic [W-1:0]       bus_o,
  output logic               bus_err_o,
  output logic [W-1:0]       ir_o
);
  logic [W-1:0] pc_q, sp_q, mar_q, mbr_q, ir_q, y_q, z_q;
  logic [NUM_GPR-1:0][W-1:0] gpr_q;
  logic [NUM_SRC-1:0][W-1:0] src;
  logic [W-1:0] bus, alu_res;
  logic         mbr_fill;

  assign src[DRV_PC]  = pc_q;
  assign src[DRV_SP]  = sp_q;
  assign src[DRV_MAR] = mar_q;
  assign src[DRV_MBR] = mbr_q;
  assign src[DRV_IR]  = ir_q;
  assign src[DRV_Y]   = y_q;
  assign src[DRV_Z]   = z_q;

  sbd_bus #(.W(W), .NUM_SRC(NUM_SRC)) u_bus (
    .src_i      (src),
    .drive_en_i (drive_en_i),
    .bus_o      (bus),
    .err_o      (bus_err_o)
  );

  sbd_alu #(.W(W)) u_alu (
    .a_i   (y_q),
    .b_i   (bus),
    .op_i  (alu_op_i),
    .res_o (alu_res)
  );

  sbd_mem_port u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (mem_rd_req_i),
    .rdy_i      (mem_rdy_i),
    .rd_o       (mem_rd_o),
    .mbr_fill_o (mbr_fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      sp_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      if (load_en_i[LD_PC])  pc_q  <= bus;
      if (load_en_i[LD_SP])  sp_q  <= bus;
      if (load_en_i[LD_MAR]) mar_q <= bus;
      if (load_en_i[LD_IR])  ir_q  <= bus;
      if (load_en_i[LD_Y])   y_q   <= bus;
      if (z_ld_i)            z_q   <= alu_res;
    end
  end

  // memory return has priority over a bus load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mbr_q <= '0;
    else if (mbr_fill)          mbr_q <= mem_rdata_i;
    else if (load_en_i[LD_MBR]) mbr_q <= bus;
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    assign src[DRV_GPR0+g] = gpr_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   gpr_q[g] <= '0;
      else if (load_en_i[LD_GPR0+g]) gpr_q[g] <= bus;
    end
  end

  assign bus_o       = bus;
  assign ir_o        = ir_q;
  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign mem_wr_o    = mem_wr_req_i;
endmodule

// File: rtl/single_bus_datapath_chk.sv
module single_bus_datapath_chk #(
  parameter int unsigned W       = 8,
  parameter int unsigned NUM_SRC = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] drive_en_i,
  input logic               ir_ld_i,
  input logic               z_ld_i,
  input logic               mem_rd_req_i,
  input logic               mem_rdy_i,
  input logic [W-1:0]       mem_rdata_i,
  input logic [W-1:0]       bus_o,
  input logic               bus_err_o,
  input logic               mem_rd_o,
  input logic [W-1:0]       mem_wdata_o,
  input logic [W-1:0]       ir_o,
  input logic [W-1:0]       z_q
);
  AST_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_en_i == '0) |-> (bus_o == '0)); // R2
  AST_ONE_DRIVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_err_o |-> $onehot0(drive_en_i)); // R3
  AST_IR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_ld_i && !bus_err_o) |=> (ir_o == $past(bus_o))); // R4
  AST_Z_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !z_ld_i |=> $stable(z_q)); // R5
  AST_RD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_o && mem_rd_req_i) |=> mem_rd_o); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_rdy_i) |=> mem_rd_o); // R7
  AST_RD_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && mem_rdy_i) |=> (!mem_rd_o && mem_wdata_o == $past(mem_rdata_i))); // R9
endmodule

bind single_bus_datapath single_bus_datapath_chk #(.W(W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .drive_en_i   (drive_en_i),
  .ir_ld_i      (load_en_i[sbd_pkg::LD_IR]),
  .z_ld_i       (z_ld_i),
  .mem_rd_req_i (mem_rd_req_i),
  .mem_rdy_i    (mem_rdy_i),
  .mem_rdata_i  (mem_rdata_i),
  .bus_o        (bus_o),
  .bus_err_o    (bus_err_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wdata_o  (mem_wdata_o),
  .ir_o         (ir_o),
  .z_q          (z_q)
);

// File: tb/single_bus_datapath_bench.sv
module single_bus_datapath_bench;
  localparam int NG = 4;
  localparam int NS = 7 + NG;
  localparam int ND = 6 + NG;

  localparam logic [NS-1:0] D_PC = NS'(1) << 0, D_SP = NS'(1) << 1, D_MAR = NS'(1) << 2,
    D_MBR = NS'(1) << 3, D_IR = NS'(1) << 4, D_Y = NS'(1) << 5, D_Z = NS'(1) << 6;
  localparam logic [ND-1:0] L_PC = ND'(1) << 0, L_SP = ND'(1) << 1, L_MAR = ND'(1) << 2,
    L_MBR = ND'(1) << 3, L_IR = ND'(1) << 4, L_Y = ND'(1) << 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] drv = '0;
  logic [ND-1:0] ld = '0;
  logic zl = 1'b0, rq = 1'b0, wr = 1'b0, rdy = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] rdata = '0;
  logic [7:0] addr, wdata, bus, ir;
  logic rd_o, wr_o, err;

  always #2 clk = ~clk;

  single_bus_datapath #(.W(8), .NUM_GPR(NG)) u_single_bus_datapath (
    .clk_i(clk), .rst_ni(rst_n), .drive_en_i(drv), .load_en_i(ld), .z_ld_i(zl),
    .alu_op_i(op), .mem_rd_req_i(rq), .mem_wr_req_i(wr), .mem_rdy_i(rdy),
    .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_rd_o(rd_o), .mem_wr_o(wr_o),
    .mem_wdata_o(wdata), .bus_o(bus), .bus_err_o(err), .ir_o(ir)
  );

  // reference model
  logic [7:0] m_pc, m_sp, m_mar, m_mbr, m_ir, m_y, m_z;
  logic [7:0] m_gpr [NG];
  logic [7:0] mem_m [256];
  logic m_pend;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] src_val(input int i);
    case (i)
      0: return m_pc;  1: return m_sp;  2: return m_mar; 3: return m_mbr;
      4: return m_ir;  5: return m_y;   6: return m_z;
      default: return m_gpr[i-7];
    endcase
  endfunction

  function automatic logic [7:0] alu_ref(input logic [2:0] f, input logic [7:0] a, input logic [7:0] b);
    case (f)
      3'd0: return a + b;   3'd1: return a - b;   3'd2: return a & b;
      3'd3: return a | b;   3'd4: return a ^ b;   3'd5: return b;
      3'd6: return b + 8'd1; default: return b - 8'd1;
    endcase
  endfunction

  task automatic cyc(input logic [NS-1:0] d, input logic [ND-1:0] l, input logic z,
                     input logic [2:0] f, input logic r, input logic w, input logic y,
                     input string tag);
    int cnt;
    logic [7:0] eb;
    @(negedge clk);
    drv = d; ld = l; zl = z; op = f; rq = r; wr = w; rdy = y;
    rdata = mem_m[m_mar];
    #1;
    cnt = 0; eb = '0;
    for (int i = 0; i < NS; i++) if (d[i]) begin cnt++; eb = src_val(i); end
    if (cnt <= 1) chk({tag, " bus"}, bus, eb);
    else eb = bus;
    chk("R3 err", {7'd0, err}, {7'd0, cnt > 1});
    chk("R7 rd", {7'd0, rd_o}, {7'd0, m_pend});
    chk("R7 addr", addr, m_mar);
    chk("R8 wr", {7'd0, wr_o}, {7'd0, w});
    chk("R8 wdata", wdata, m_mbr);
    chk("R10 ir", ir, m_ir);
    if (w) mem_m[m_mar] = m_mbr;
    if (z) m_z = alu_ref(f, m_y, eb);
    if (m_pend && y) m_mbr = rdata;
    else if (l[3]) m_mbr = eb;
    if (l[0]) m_pc = eb;
    if (l[1]) m_sp = eb;
    if (l[2]) m_mar = eb;
    if (l[4]) m_ir = eb;
    if (l[5]) m_y = eb;
    for (int g = 0; g < NG; g++) if (l[6+g]) m_gpr[g] = eb;
    if (m_pend && y) m_pend = 1'b0;
    else if (!m_pend && r) m_pend = 1'b1;
    @(posedge clk);
  endtask

  task automatic mv(input logic [NS-1:0] d, input logic [ND-1:0] l, input string tag);
    cyc(d, l, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic alu(input logic [NS-1:0] d, input logic [2:0] f, input string tag);
    cyc(d, '0, 1'b1, f, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input int waits, input string tag);
    cyc('0, '0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, tag);
    for (int k = 0; k < waits; k++) cyc('0, '0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, tag);
    cyc('0, '0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  task automatic fetch_to(input logic [ND-1:0] dst, input int waits);
    mv(D_PC, L_MAR, "R4");
    rd(waits, "R7");
    mv(D_MBR, dst, "R4");
    alu(D_PC, 3'd6, "R6");
    mv(D_Z, L_PC, "R6");
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_pc = '0; m_sp = '0; m_mar = '0; m_mbr = '0; m_ir = '0; m_y = '0; m_z = '0;
    m_pend = 1'b0;
    for (int g = 0; g < NG; g++) m_gpr[g] = '0;
    for (int a = 0; a < 256; a++) mem_m[a] = 8'((a * 37 + 200) & 255);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < NS; i++) mv(NS'(1) << i, '0, "R1");
    mv('0, '0, "R2");

    // fetch into IR, then PC step
    fetch_to(L_IR, 2);
    mv(D_IR, '0, "R10");
    for (int g = 0; g < NG; g++) fetch_to(ND'(1) << (6 + g), g % 2);
    for (int i = 0; i < NS; i++) mv(NS'(1) << i, '0, "R2");

    // R6: all ALU functions, Y = gpr0, B = gpr1
    mv(D_Z, '0, "R6");
    mv(NS'(1) << 7, L_Y, "R4");
    for (int f = 0; f < 8; f++) begin
      alu(NS'(1) << 8, 3'(f), "R6");
      mv(D_Z, '0, "R6");
    end
    // R6: wrap on add with gpr2 and gpr3
    mv(NS'(1) << 9, L_Y, "R4");
    alu(NS'(1) << 10, 3'd0, "R6");
    mv(D_Z, NS'(1) << 0 == '0 ? '0 : ND'(1) << 9, "R6");

    // R5: no capture without strobe
    cyc(NS'(1) << 8, '0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, "R5");
    mv(D_Z, '0, "R5");

    // SP decrement below zero, then push PC
    alu(D_SP, 3'd7, "R6");
    mv(D_Z, L_SP, "R6");
    mv(D_SP, L_MAR, "R6");
    mv(D_PC, L_MBR, "R4");
    cyc('0, '0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, "R8");
    // pop back into PC, with SP increment
    mv(D_PC, L_Y, "R4");
    mv(D_Y, L_MBR, "R4");
    rd(1, "R7");
    mv(D_MBR, L_PC, "R8");
    alu(D_SP, 3'd6, "R6");
    mv(D_Z, L_SP, "R6");
    mv(D_SP, '0, "R6");

    // R9: read return collides with bus load of MBR
    cyc('0, '0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, "R9");
    cyc(NS'(1) << 9, L_MBR, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R9");
    mv(D_MBR, '0, "R9");
    // R9: ready with nothing pending
    cyc(D_PC, L_MBR, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R9");
    cyc('0, '0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R9");
    mv(D_MBR, '0, "R9");

    // R7: repeated request while pending
    cyc('0, '0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, "R7");
    cyc('0, '0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, "R7");
    cyc('0, '0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7");
    mv('0, '0, "R7");
    mv(D_MBR, '0, "R7");

    // R3: two drivers
    mv(D_PC | D_SP, '0, "R3");
    mv(D_Z | D_Y | D_IR, '0, "R3");
    mv('0, '0, "R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule